// File: doc/BRIEF.md
# Control Register File with Write Side-Effects

This block holds the control state of a paging-capable processor core: paging control word 0, the fault-address word 2, the page-table base word 3, the feature-control word 4, the priority word 8, and an extended feature word. All registers are 64 bits wide. There is one write port and one combinational read port, and both select a register by a 5-bit index. An index that names no implemented register is reported on an error output. It never changes state.

Writes come in two kinds. An architectural write applies the side effects that belong to the register being written. The block finds the toggled bits by XOR of the old and new values. From those bits it forces fixed bits, updates the long-mode-active flag, and raises one-cycle flush requests towards the instruction and data translation buffers. A raw write, selected with `wr_raw`, stores the value exactly as given and has none of these effects. The translation buffers, the instruction decode and the privilege checks sit outside this block.

Top module: `ctrlreg_file`

## Requirements
- R1: Index map: 0, 2, 3, 4 and 8 select control words 0, 2, 3, 4 and 8, and 16 selects the extended feature word. Every other index (1, 5–7, 9–15, 17–31) is illegal. A read is combinational: `rd_data` is the stored value, and `rd_err` is 0 for a legal index. For an illegal index `rd_data` is 0 and `rd_err` is 1.
- R2: A write with an illegal index raises `wr_err` in the same cycle. It changes no register and raises no flush request.
- R3: An architectural write to word 0 stores the supplied value with bit 4 forced to 1.
- R4: When an architectural write to word 0 changes bit 31 (paging enable) and bit 8 (long-mode enable) of the extended word is 1, bit 10 (long-mode active) of the extended word takes the new bit 31. When bit 8 is 0, the extended word is left unchanged.
- R5: An architectural write to word 0 that changes bit 31 raises the full-flush outputs of both buffers in the next cycle, for one cycle. A write to word 0 that leaves bit 31 unchanged raises no flush.
- R6: Every architectural write to word 3 raises the non-global flush outputs of both buffers in the next cycle, for one cycle. The full-flush outputs stay low. In any cycle at most one flush kind is active, and a full flush takes priority over a non-global one.
- R7: An architectural write to word 4 that changes bit 4, 5 or 7 raises the full-flush outputs of both buffers in the next cycle. A write that changes only other bits raises no flush.
- R8: Architectural writes to word 2, word 8 and the extended word store the value unchanged and raise no flush.
- R9: A raw write (`wr_raw`=1) to a legal index stores the value unchanged, bit 4 of word 0 included. It raises no flush and leaves long-mode active as it was.
- R10: After reset, word 0 reads 0x10, every other register reads 0, and all flush outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_raw | input | 1 | 1 = raw write without side effects |
| wr_idx | input | 5 | Write register index |
| wr_data | input | 64 | Write value |
| wr_err | output | 1 | Write index is illegal (combinational) |
| rd_idx | input | 5 | Read register index |
| rd_data | output | 64 | Read value |
| rd_err | output | 1 | Read index is illegal |
| itlb_flush_full | output | 1 | Instruction buffer full-flush pulse |
| itlb_flush_local | output | 1 | Instruction buffer non-global flush pulse |
| dtlb_flush_full | output | 1 | Data buffer full-flush pulse |
| dtlb_flush_local | output | 1 | Data buffer non-global flush pulse |

## Verification
The hardest case to reach is an architectural write to word 0 that changes paging enable while the long-mode-enable bit has a chosen value, because each half of that condition depends on earlier writes. The vector table first sets long-mode enable through the extended word and then toggles paging on and off. It clears long-mode enable with a raw write. It then uses a raw write to word 0 to leave paging set without a flush, so that the next architectural write toggles paging with long-mode enable cleared. Each row reads back the register the side effect should have touched.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

    localparam int REG_W = 64;
    localparam int IDX_W = 5;

    localparam logic [IDX_W-1:0] IDX_W0 = 5'd0;
    localparam logic [IDX_W-1:0] IDX_W2 = 5'd2;
    localparam logic [IDX_W-1:0] IDX_W3 = 5'd3;
    localparam logic [IDX_W-1:0] IDX_W4 = 5'd4;
    localparam logic [IDX_W-1:0] IDX_W8 = 5'd8;
    localparam logic [IDX_W-1:0] IDX_XF = 5'd16;

    localparam int W0_PG_BIT  = 31;
    localparam int W0_FIX_BIT = 4;
    localparam int W4_PSE_BIT = 4;
    localparam int W4_PAE_BIT = 5;
    localparam int W4_PGE_BIT = 7;
    localparam int XF_LME_BIT = 8;
    localparam int XF_LMA_BIT = 10;

    localparam logic [REG_W-1:0] W0_RESET = REG_W'(1) << W0_FIX_BIT;
    localparam logic [REG_W-1:0] W4_FLUSH_MASK =
        (REG_W'(1) << W4_PSE_BIT) | (REG_W'(1) << W4_PAE_BIT) | (REG_W'(1) << W4_PGE_BIT);

    typedef enum logic [2:0] {
        SEL_W0,
        SEL_W2,
        SEL_W3,
        SEL_W4,
        SEL_W8,
        SEL_XF,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/ctrlreg_decode.sv
module ctrlreg_decode
    import ctrlreg_pkg::*;
#(
    parameter int IW = IDX_W
) (
    input  logic [IW-1:0] idx,
    output reg_sel_e      sel,
    output logic          legal
);

    always_comb begin
        case (idx)
            IW'(IDX_W0): sel = SEL_W0;
            IW'(IDX_W2): sel = SEL_W2;
            IW'(IDX_W3): sel = SEL_W3;
            IW'(IDX_W4): sel = SEL_W4;
            IW'(IDX_W8): sel = SEL_W8;
            IW'(IDX_XF): sel = SEL_XF;
            default:     sel = SEL_NONE;
        endcase
        legal = (sel != SEL_NONE);
    end

endmodule

// File: rtl/ctrlreg_effects.sv
module ctrlreg_effects
    import ctrlreg_pkg::*;
#(
    parameter int DW = REG_W
) (
    input  logic          arch_wr,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] w0_old,
    input  logic [DW-1:0] w4_old,
    input  logic [DW-1:0] xf_old,
    output logic [DW-1:0] w0_fixed,
    output logic          lma_upd,
    output logic          lma_val,
    output logic          flush_full,
    output logic          flush_local
);

    logic [DW-1:0] w0_tog;
    logic [DW-1:0] w4_tog;
    logic          pg_tog;

    always_comb begin
        w0_tog      = w0_old ^ wdata;
        w4_tog      = w4_old ^ wdata;
        pg_tog      = w0_tog[W0_PG_BIT];
        w0_fixed    = wdata;
        w0_fixed[W0_FIX_BIT] = 1'b1;
        lma_upd     = 1'b0;
        lma_val     = wdata[W0_PG_BIT];
        flush_full  = 1'b0;
        flush_local = 1'b0;
        if (arch_wr) begin
            case (sel)
                SEL_W0: begin
                    flush_full = pg_tog;
                    lma_upd    = pg_tog & xf_old[XF_LME_BIT];
                end
                SEL_W3: flush_local = 1'b1;
                SEL_W4: flush_full  = |(w4_tog & DW'(W4_FLUSH_MASK));
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctrlreg_file.sv
module ctrlreg_file
    import ctrlreg_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_raw,
    input  logic [ADDR_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_err,
    input  logic [ADDR_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_err,
    output logic              itlb_flush_full,
    output logic              itlb_flush_local,
    output logic              dtlb_flush_full,
    output logic              dtlb_flush_local
);

    typedef struct packed {
        logic [DATA_W-1:0] w0;
        logic [DATA_W-1:0] w2;
        logic [DATA_W-1:0] w3;
        logic [DATA_W-1:0] w4;
        logic [DATA_W-1:0] w8;
        logic [DATA_W-1:0] xf;
        logic              fl_full;
        logic              fl_local;
    } state_t;

    state_t state_d, state_q;

    reg_sel_e wr_sel, rd_sel;
    logic     wr_legal, rd_legal;
    logic     arch_wr;

    logic [DATA_W-1:0] w0_fixed;
    logic              lma_upd, lma_val;
    logic              fx_full, fx_local;

    ctrlreg_decode #(.IW(ADDR_W)) u_wr_dec (
        .idx   (wr_idx),
        .sel   (wr_sel),
        .legal (wr_legal)
    );

    ctrlreg_decode #(.IW(ADDR_W)) u_rd_dec (
        .idx   (rd_idx),
        .sel   (rd_sel),
        .legal (rd_legal)
    );

    assign arch_wr = wr_en & ~wr_raw & wr_legal;

    ctrlreg_effects #(.DW(DATA_W)) u_fx (
        .arch_wr     (arch_wr),
        .sel         (wr_sel),
        .wdata       (wr_data),
        .w0_old      (state_q.w0),
        .w4_old      (state_q.w4),
        .xf_old      (state_q.xf),
        .w0_fixed    (w0_fixed),
        .lma_upd     (lma_upd),
        .lma_val     (lma_val),
        .flush_full  (fx_full),
        .flush_local (fx_local)
    );

    always_comb begin
        state_d          = state_q;
        state_d.fl_full  = fx_full;
        state_d.fl_local = fx_local & ~fx_full;
        if (wr_en && wr_legal) begin
            case (wr_sel)
                SEL_W0: begin
                    state_d.w0 = wr_raw ? wr_data : w0_fixed;
                    if (lma_upd) begin
                        state_d.xf[XF_LMA_BIT] = lma_val;
                    end
                end
                SEL_W2:  state_d.w2 = wr_data;
                SEL_W3:  state_d.w3 = wr_data;
                SEL_W4:  state_d.w4 = wr_data;
                SEL_W8:  state_d.w8 = wr_data;
                SEL_XF:  state_d.xf = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= '0;
            state_q.w0       <= DATA_W'(W0_RESET);
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (rd_sel)
            SEL_W0:  rd_data = state_q.w0;
            SEL_W2:  rd_data = state_q.w2;
            SEL_W3:  rd_data = state_q.w3;
            SEL_W4:  rd_data = state_q.w4;
            SEL_W8:  rd_data = state_q.w8;
            SEL_XF:  rd_data = state_q.xf;
            default: rd_data = '0;
        endcase
    end

    assign rd_err           = ~rd_legal;
    assign wr_err           = wr_en & ~wr_legal;
    assign itlb_flush_full  = state_q.fl_full;
    assign dtlb_flush_full  = state_q.fl_full;
    assign itlb_flush_local = state_q.fl_local;
    assign dtlb_flush_local = state_q.fl_local;

endmodule

// File: rtl/ctrlreg_file_chk.sv
module ctrlreg_file_chk
    import ctrlreg_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_raw,
    input logic              wr_err,
    input logic [ADDR_W-1:0] wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              ifull,
    input logic              iloc,
    input logic              dfull,
    input logic              dloc,
    input logic [DATA_W-1:0] w0,
    input logic [DATA_W-1:0] w4,
    input logic [DATA_W-1:0] xf
);

    logic arch_w0;
    assign arch_w0 = wr_en && !wr_raw && !wr_err && (wr_idx == ADDR_W'(IDX_W0));

    // R2
    illegal_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_err |=> $stable(w0) && $stable(w4) && $stable(xf) && !ifull && !iloc)
        else $error("illegal write changed state");

    // R3
    fixed_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arch_w0 |=> w0[W0_FIX_BIT])
        else $error("word 0 fixed bit not set");

    // R4
    lm_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arch_w0 && (w0[W0_PG_BIT] != wr_data[W0_PG_BIT]) && xf[XF_LME_BIT]
        |=> xf[XF_LMA_BIT] == $past(wr_data[W0_PG_BIT]))
        else $error("long-mode active not updated");

    // R5
    pg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arch_w0 && (w0[W0_PG_BIT] != wr_data[W0_PG_BIT]) |=> ifull && dfull)
        else $error("paging toggle without full flush");

    // R6
    w3_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_raw && (wr_idx == ADDR_W'(IDX_W3)) |=> iloc && dloc && !ifull)
        else $error("word 3 write without non-global flush");

    // R6
    flush_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ifull && iloc) && !(dfull && dloc))
        else $error("both flush kinds active");

    // R9
    raw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_raw |=> !ifull && !iloc && !dfull && !dloc)
        else $error("raw write raised a flush");

endmodule

bind ctrlreg_file ctrlreg_file_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_raw  (wr_raw),
    .wr_err  (wr_err),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ifull   (itlb_flush_full),
    .iloc    (itlb_flush_local),
    .dfull   (dtlb_flush_full),
    .dloc    (dtlb_flush_local),
    .w0      (state_q.w0),
    .w4      (state_q.w4),
    .xf      (state_q.xf)
);

// File: tb/tb_ctrlreg_file.sv
module tb_ctrlreg_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_raw = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [4:0]  rd_idx = '0;
    logic [63:0] rd_data;
    logic        rd_err;
    logic        iff_o, ilo_o, dff_o, dlo_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ctrlreg_file dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_raw(wr_raw),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err),
        .itlb_flush_full(iff_o), .itlb_flush_local(ilo_o),
        .dtlb_flush_full(dff_o), .dtlb_flush_local(dlo_o)
    );

    typedef struct packed {
        logic        raw;
        logic [4:0]  widx;
        logic [63:0] wdata;
        logic [4:0]  ridx;
        logic [63:0] exp;
        logic        full;
        logic        loc;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd16, 64'h100,                 5'd16, 64'h100,                 1'b0, 1'b0}, // R8
        '{1'b0, 5'd0,  64'h8000_0001,           5'd16, 64'h500,                 1'b1, 1'b0}, // R4 R5
        '{1'b0, 5'd2,  64'hDEAD_BEEF_0000_1234, 5'd0,  64'h8000_0011,           1'b0, 1'b0}, // R3 R8
        '{1'b0, 5'd0,  64'h8000_0001,           5'd0,  64'h8000_0011,           1'b0, 1'b0}, // R5 no toggle
        '{1'b0, 5'd3,  64'h5000,                5'd3,  64'h5000,                1'b0, 1'b1}, // R6
        '{1'b0, 5'd3,  64'h5000,                5'd3,  64'h5000,                1'b0, 1'b1}, // R6 same value
        '{1'b0, 5'd4,  64'h20,                  5'd4,  64'h20,                  1'b1, 1'b0}, // R7 bit5
        '{1'b0, 5'd4,  64'h21,                  5'd4,  64'h21,                  1'b0, 1'b0}, // R7 bit0 only
        '{1'b0, 5'd4,  64'h81,                  5'd4,  64'h81,                  1'b1, 1'b0}, // R7 bits5,7
        '{1'b0, 5'd0,  64'h1,                   5'd16, 64'h100,                 1'b1, 1'b0}, // R4 R5 off
        '{1'b1, 5'd0,  64'h8000_0000,           5'd0,  64'h8000_0000,           1'b0, 1'b0}, // R9
        '{1'b0, 5'd8,  64'hF,                   5'd2,  64'hDEAD_BEEF_0000_1234, 1'b0, 1'b0}, // R8
        '{1'b1, 5'd16, 64'h0,                   5'd16, 64'h0,                   1'b0, 1'b0}, // R9
        '{1'b0, 5'd0,  64'h0,                   5'd16, 64'h0,                   1'b1, 1'b0}, // R4 no LME
        '{1'b1, 5'd3,  64'h7000,                5'd3,  64'h7000,                1'b0, 1'b0}, // R9
        '{1'b0, 5'd2,  64'h1,                   5'd8,  64'hF,                   1'b0, 1'b0}  // R8
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_flush(input string req, input logic full, input logic loc);
        chk(iff_o == full && dff_o == full, req, {62'd0, iff_o, dff_o}, {62'd0, full, full});
        chk(ilo_o == loc && dlo_o == loc, req, {62'd0, ilo_o, dlo_o}, {62'd0, loc, loc});
    endtask

    task automatic do_write(input logic raw, input logic [4:0] idx, input logic [63:0] d, input logic [4:0] ridx);
        @(negedge clk);
        wr_en = 1'b1; wr_raw = raw; wr_idx = idx; wr_data = d; rd_idx = ridx;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        rd_idx = 5'd0; #1;
        chk(rd_data == 64'h10, "R10 word0", rd_data, 64'h10);
        for (int i = 1; i < 32; i++) begin
            rd_idx = 5'(i); #1;
            if (!rd_err) chk(rd_data == 0, "R10 zero", rd_data, 0);
        end
        chk_flush("R10 flush", 1'b0, 1'b0);

        // R1 illegal read
        foreach (VEC[k]) begin end
        for (int i = 0; i < 32; i++) begin
            logic lg;
            lg = (i == 0 || i == 2 || i == 3 || i == 4 || i == 8 || i == 16);
            rd_idx = 5'(i); #1;
            chk(rd_err == !lg, "R1 rd_err", {63'd0, rd_err}, {63'd0, !lg});
            if (!lg) chk(rd_data == 0, "R1 illegal data", rd_data, 0);
        end

        // table
        for (int k = 0; k < NV; k++) begin
            do_write(VEC[k].raw, VEC[k].widx, VEC[k].wdata, VEC[k].ridx);
            chk(rd_data == VEC[k].exp, $sformatf("row %0d read", k), rd_data, VEC[k].exp);
            chk_flush($sformatf("row %0d flush", k), VEC[k].full, VEC[k].loc);
        end

        // R5 single-cycle pulse
        do_write(1'b0, 5'd0, 64'h8000_0000, 5'd0);
        chk_flush("R5 pulse", 1'b1, 1'b0);
        @(posedge clk); #1;
        chk_flush("R5 pulse ends", 1'b0, 1'b0);
        chk(rd_data == 64'h8000_0010, "R3 word0", rd_data, 64'h8000_0010);

        // R2 illegal writes
        for (int j = 0; j < 6; j++) begin
            logic [4:0] bad;
            case (j)
                0: bad = 5'd1; 1: bad = 5'd5; 2: bad = 5'd9;
                3: bad = 5'd15; 4: bad = 5'd17; default: bad = 5'd31;
            endcase
            @(negedge clk);
            wr_en = 1'b1; wr_raw = j[0]; wr_idx = bad; wr_data = '1; rd_idx = 5'd0;
            #1;
            chk(wr_err == 1'b1, "R2 wr_err", {63'd0, wr_err}, 64'd1);
            @(posedge clk); #1;
            wr_en = 1'b0;
            chk_flush("R2 no flush", 1'b0, 1'b0);
        end
        rd_idx = 5'd0;  #1; chk(rd_data == 64'h8000_0010, "R2 word0 kept", rd_data, 64'h8000_0010);
        rd_idx = 5'd4;  #1; chk(rd_data == 64'h81, "R2 word4 kept", rd_data, 64'h81);
        rd_idx = 5'd16; #1; chk(rd_data == 64'h0, "R2 xf kept", rd_data, 64'h0);
        rd_idx = 5'd1;  #1; chk(rd_data == 64'h0 && rd_err, "R1 idx1", rd_data, 64'h0);

        // legal write has no wr_err
        @(negedge clk);
        wr_en = 1'b1; wr_raw = 1'b0; wr_idx = 5'd8; wr_data = 64'h3; #1;
        chk(wr_err == 1'b0, "R2 legal no err", {63'd0, wr_err}, 64'd0);
        @(posedge clk); #1; wr_en = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule